// File: doc/BRIEF.md
# Indexed Memory Region Translator

This block sits between a client master and memory. The client never handles physical addresses. It names a region through a small index and supplies an offset inside that region. A host loads an on-chip table of region descriptors through a write port that is separate from the data path. Each descriptor holds a physical base, a region length and a byte-order flag. For each client access the block looks up the descriptor and compares the offset with the length. An access that fits is forwarded with the physical address `base + offset`. An access that does not fit is dropped before it reaches memory, and the block records it.

The client supplies one configuration word that packs three region indices, one for each of the Y, U and V planes. A two-bit plane code selects which of the three indices an access uses. Write data passes through a byte swap before it goes to memory. Read data passes through the same swap on its way back. In both directions the swap follows the flag of the descriptor the access used.

Control is a three-state machine:
- `ST_IDLE` accepts requests.
- `ST_ISSUE` presents the registered request to memory until memory takes it.
- `ST_RDWAIT` holds off the client until read data returns.

The transitions are:
- `IDLE→ISSUE`: an in-range request is accepted.
- `IDLE→IDLE`: a blocked request is consumed and flagged.
- `ISSUE→IDLE`: memory accepts a write.
- `ISSUE→RDWAIT`: memory accepts a read.
- `RDWAIT→IDLE`: read data returns.

Top module: `region_xlate`

## Requirements
- R1: After reset `c_ready`=1, `m_valid`=0, `c_rvalid`=0 and `err_flag`=0. Every table entry has length zero, so any access is blocked until the host writes the entry.
- R2: A table write (`tw_en`=1 with index, base, length and big-endian flag) is seen by a client request accepted on any later clock edge. A rewrite replaces the old descriptor.
- R3: `c_plane` selects the index field of `c_cfg`: 0 selects bits [7:0] (Y), 1 selects [15:8] (U), 2 selects [23:16] (V). Code 3 is reserved. Such an access is blocked and reported with index 0.
- R4: An accepted request with offset < length drives `m_valid`=1 from the next clock edge, with `m_addr`=base+offset and `m_we` equal to the client's `c_we`.
- R5: A request with offset ≥ length never raises `m_valid`. It sets `err_flag` and captures the index in `err_idx` and the offset in `err_off`.
- R6: An entry whose length is zero blocks every access, offset 0 included.
- R7: `err_flag` stays set and keeps the first captured index and offset until `err_clr`=1 for a clock. If a blocked access arrives in the same cycle as `err_clr`, the flag stays set and the new access is captured.
- R8: With the entry's big-endian flag set, `m_wdata` is `c_wdata` with its 8 bytes reversed (byte 0 ↔ byte 7, bits [7:0] ↔ [63:56]). With the flag clear, `m_wdata` is unchanged.
- R9: For a read, `c_rvalid` pulses one clock after `m_rvalid` is sampled in `ST_RDWAIT`. `c_rdata` is `m_rdata`, byte-reversed when the entry of that read is big-endian and unchanged otherwise.
- R10: While `m_valid`=1 and `m_ready`=0, `m_addr`, `m_we` and `m_wdata` hold steady. `c_ready` stays 0 from acceptance until the write is taken or the read data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 8 | Entry to write |
| tw_base | input | 32 | Physical base of the region |
| tw_size | input | 32 | Region length in bytes (0 = invalid) |
| tw_big | input | 1 | Big-endian flag of the entry |
| err_clr | input | 1 | Write-one-to-clear of the error record |
| err_flag | output | 1 | Sticky blocked-access flag |
| err_idx | output | 8 | Index of the captured blocked access |
| err_off | output | 32 | Offset of the captured blocked access |
| c_valid | input | 1 | Client request valid |
| c_ready | output | 1 | Block can take a request |
| c_plane | input | 2 | Plane select (0 Y, 1 U, 2 V, 3 reserved) |
| c_cfg | input | 24 | Three packed region indices |
| c_off | input | 32 | Offset within the region |
| c_we | input | 1 | 1 = write, 0 = read |
| c_wdata | input | 64 | Client write data |
| c_rvalid | output | 1 | Read data valid toward the client |
| c_rdata | output | 64 | Read data toward the client |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory takes the request |
| m_addr | output | 32 | Physical address |
| m_we | output | 1 | Memory write enable |
| m_wdata | output | 64 | Memory write data |
| m_rvalid | input | 1 | Memory read data valid |
| m_rdata | input | 64 | Memory read data |

## Verification
The test patterns fall into a few groups:
- **Plane routing.** Requests go through each plane code against entries with distinct bases. This exposes a wrong field selection in the configuration word.
- **Bounds.** Offsets at length−1 and at exactly length separate an off-by-one compare from a correct one. A zero-length entry and a reserved plane code cover the other two ways a request is blocked.
- **Error record.** Errors arrive back to back and together with a clear. This tells first-capture retention apart from overwrite-on-every-error.
- **Byte order and backpressure.** Asymmetric byte patterns on both data directions, with both flag values, expose a missing or wrong swap. A multi-cycle memory stall shows whether the request holds steady and the client is held off.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_RDWAIT = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        PL_Y   = 2'd0,
        PL_U   = 2'd1,
        PL_V   = 2'd2,
        PL_RSV = 2'd3
    } plane_e;
endpackage

// File: rtl/rx_table.sv
module rx_table #(
    parameter int IDX_W = 8,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tw_en,
    input  logic [IDX_W-1:0] tw_idx,
    input  logic [AW-1:0]    tw_base,
    input  logic [AW-1:0]    tw_size,
    input  logic             tw_big,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_base,
    output logic [AW-1:0]    rd_size,
    output logic             rd_big
);
    localparam int NENT = 1 << IDX_W;

    logic [AW-1:0] base_q [NENT];
    logic [AW-1:0] size_q [NENT];
    logic          big_q  [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
                big_q[i]  <= 1'b0;
            end
        end else if (tw_en) begin
            base_q[tw_idx] <= tw_base;
            size_q[tw_idx] <= tw_size;
            big_q[tw_idx]  <= tw_big;
        end
    end

    assign rd_base = base_q[rd_idx];
    assign rd_size = size_q[rd_idx];
    assign rd_big  = big_q[rd_idx];

    AST_TBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |=> (size_q[$past(tw_idx)] == $past(tw_size)) && (base_q[$past(tw_idx)] == $past(tw_base))); // R2
endmodule

// File: rtl/rx_byteswap.sv
module rx_byteswap #(
    parameter int DW = 64
) (
    input  logic          swap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[8*b +: 8] = swap ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
    end

    always_comb begin
        if (!swap) begin
            AST_SWAP_PASS: assert (dout == din); // R8
        end
    end
endmodule

// File: rtl/region_xlate.sv
module region_xlate #(
    parameter int IDX_W = 8,
    parameter int AW    = 32,
    parameter int DW    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [AW-1:0]      tw_base,
    input  logic [AW-1:0]      tw_size,
    input  logic               tw_big,
    input  logic               err_clr,
    output logic               err_flag,
    output logic [IDX_W-1:0]   err_idx,
    output logic [AW-1:0]      err_off,
    input  logic               c_valid,
    output logic               c_ready,
    input  logic [1:0]         c_plane,
    input  logic [3*IDX_W-1:0] c_cfg,
    input  logic [AW-1:0]      c_off,
    input  logic               c_we,
    input  logic [DW-1:0]      c_wdata,
    output logic               c_rvalid,
    output logic [DW-1:0]      c_rdata,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [AW-1:0]      m_addr,
    output logic               m_we,
    output logic [DW-1:0]      m_wdata,
    input  logic               m_rvalid,
    input  logic [DW-1:0]      m_rdata
);
    import rx_pkg::*;

    xl_state_e        state_q, state_d;
    logic [IDX_W-1:0] sel_idx;
    logic             plane_ok;
    logic [AW-1:0]    lk_base, lk_size;
    logic             lk_big;
    logic             hit, accept;
    logic [DW-1:0]    wdata_sw, rdata_sw;
    logic             rd_big_q;

    // plane decode
    always_comb begin
        plane_ok = 1'b1;
        sel_idx  = '0;
        unique case (plane_e'(c_plane))
            PL_Y:    sel_idx = c_cfg[0*IDX_W +: IDX_W];
            PL_U:    sel_idx = c_cfg[1*IDX_W +: IDX_W];
            PL_V:    sel_idx = c_cfg[2*IDX_W +: IDX_W];
            default: plane_ok = 1'b0;
        endcase
    end

    rx_table #(.IDX_W(IDX_W), .AW(AW)) tbl_i (
        .clk(clk), .rst_n(rst_n),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base),
        .tw_size(tw_size), .tw_big(tw_big),
        .rd_idx(sel_idx), .rd_base(lk_base), .rd_size(lk_size), .rd_big(lk_big)
    );

    rx_byteswap #(.DW(DW)) wswap_i (.swap(lk_big),   .din(c_wdata), .dout(wdata_sw));
    rx_byteswap #(.DW(DW)) rswap_i (.swap(rd_big_q), .din(m_rdata), .dout(rdata_sw));

    assign hit     = plane_ok && (lk_size != '0) && (c_off < lk_size);
    assign c_ready = (state_q == ST_IDLE);
    assign accept  = c_valid && c_ready;
    assign m_valid = (state_q == ST_ISSUE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && hit) state_d = ST_ISSUE;
            ST_ISSUE:  if (m_ready)       state_d = m_we ? ST_IDLE : ST_RDWAIT;
            ST_RDWAIT: if (m_rvalid)      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr   <= '0;
            m_we     <= 1'b0;
            m_wdata  <= '0;
            rd_big_q <= 1'b0;
            c_rvalid <= 1'b0;
            c_rdata  <= '0;
            err_flag <= 1'b0;
            err_idx  <= '0;
            err_off  <= '0;
        end else begin
            c_rvalid <= (state_q == ST_RDWAIT) && m_rvalid;
            if ((state_q == ST_RDWAIT) && m_rvalid) c_rdata <= rdata_sw;
            if (accept && hit) begin
                m_addr   <= lk_base + c_off;
                m_we     <= c_we;
                m_wdata  <= wdata_sw;
                rd_big_q <= lk_big;
            end
            if (accept && !hit) begin
                err_flag <= 1'b1;
                if (!err_flag || err_clr) begin
                    err_idx <= sel_idx;
                    err_off <= c_off;
                end
            end else if (err_clr) begin
                err_flag <= 1'b0;
            end
        end
    end

    AST_BLOCKED_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> !m_valid); // R5
    AST_ISSUE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(accept && hit)); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wdata) && $stable(m_we))); // R10
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !c_ready); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R7
    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        c_rvalid |-> $past(m_rvalid)); // R9
endmodule

// File: tb/region_xlate_tb_top.sv
module region_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tw_en = 0, tw_big = 0, err_clr = 0;
    logic [7:0]  tw_idx = 0;
    logic [31:0] tw_base = 0, tw_size = 0;
    logic        err_flag;
    logic [7:0]  err_idx;
    logic [31:0] err_off;
    logic        c_valid = 0, c_we = 0;
    logic        c_ready, c_rvalid;
    logic [1:0]  c_plane = 0;
    logic [23:0] c_cfg = 0;
    logic [31:0] c_off = 0;
    logic [63:0] c_wdata = 0, c_rdata;
    logic        m_valid, m_we;
    logic        m_ready = 0, m_rvalid = 0;
    logic [31:0] m_addr;
    logic [63:0] m_wdata, m_rdata = 0;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    region_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base), .tw_size(tw_size), .tw_big(tw_big),
        .err_clr(err_clr), .err_flag(err_flag), .err_idx(err_idx), .err_off(err_off),
        .c_valid(c_valid), .c_ready(c_ready), .c_plane(c_plane), .c_cfg(c_cfg), .c_off(c_off),
        .c_we(c_we), .c_wdata(c_wdata), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_entry(input logic [7:0] idx, input logic [31:0] base,
                            input logic [31:0] size, input logic big);
        @(negedge clk);
        tw_en = 1; tw_idx = idx; tw_base = base; tw_size = size; tw_big = big;
        @(negedge clk);
        tw_en = 0;
    endtask

    // presents a request for one edge; returns at the negedge after acceptance
    task automatic issue(input logic [1:0] pl, input logic [23:0] cfg, input logic [31:0] off,
                         input logic we, input logic [63:0] wd);
        @(negedge clk);
        c_valid = 1; c_plane = pl; c_cfg = cfg; c_off = off; c_we = we; c_wdata = wd;
        @(negedge clk);
        c_valid = 0;
    endtask

    task automatic mem_take();
        m_ready = 1;
        @(negedge clk);
        m_ready = 0;
    endtask

    task automatic mem_ret(input logic [63:0] d);
        m_rvalid = 1; m_rdata = d;
        @(negedge clk);
        m_rvalid = 0;
    endtask

    localparam logic [23:0] CFG = {8'd200, 8'd3, 8'd10};

    task automatic t_reset();
        chk("R1 c_ready", c_ready, 1);
        chk("R1 m_valid", m_valid, 0);
        chk("R1 c_rvalid", c_rvalid, 0);
        chk("R1 err_flag", err_flag, 0);
        issue(2'd0, 24'd5, 32'd0, 1'b1, 64'd0);
        chk("R1 unwritten entry blocked", m_valid, 0);
        chk("R1 unwritten entry flagged", err_flag, 1);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    endtask

    task automatic t_little_write();
        wr_entry(8'd10, 32'h0001_0000, 32'h0010_0000, 1'b0);
        issue(2'd0, CFG, 32'h40, 1'b1, 64'h0011_2233_4455_6677);
        chk("R2/R4 m_valid", m_valid, 1);
        chk("R4 m_addr", m_addr, 32'h0001_0040);
        chk("R4 m_we", m_we, 1);
        chk("R8 little unchanged", m_wdata, 64'h0011_2233_4455_6677);
        mem_take();
        chk("R10 ready after write taken", c_ready, 1);
    endtask

    task automatic t_planes();
        wr_entry(8'd3, 32'h2000_0000, 32'h1000, 1'b1);
        wr_entry(8'd200, 32'h8000_0000, 32'h10, 1'b0);
        issue(2'd1, CFG, 32'h10, 1'b1, 64'h0011_2233_4455_6677);
        chk("R3 U plane addr", m_addr, 32'h2000_0010);
        chk("R8 big swap", m_wdata, 64'h7766_5544_3322_1100);
        mem_take();
        issue(2'd2, CFG, 32'hF, 1'b1, 64'h1);
        chk("R3 V plane addr", m_addr, 32'h8000_000F);
        chk("R6/R5 last byte in range", m_valid, 1);
        mem_take();
        issue(2'd3, CFG, 32'h0, 1'b1, 64'h1);
        chk("R3 reserved plane blocked", m_valid, 0);
        chk("R3 reserved plane flag", err_flag, 1);
        chk("R3 reserved plane idx", err_idx, 0);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R7 cleared", err_flag, 0);
    endtask

    task automatic t_bounds();
        issue(2'd0, CFG, 32'h000F_FFFF, 1'b0, 64'h0);
        chk("R4 last offset ok", m_addr, 32'h0010_FFFF);
        mem_take();
        mem_ret(64'h0);
        @(negedge clk);
        issue(2'd0, CFG, 32'h0010_0000, 1'b1, 64'h0);
        chk("R5 at size blocked", m_valid, 0);
        chk("R5 flag", err_flag, 1);
        chk("R5 idx", err_idx, 10);
        chk("R5 off", err_off, 32'h0010_0000);
        issue(2'd2, CFG, 32'h10, 1'b1, 64'h0);
        chk("R7 first kept idx", err_idx, 10);
        chk("R7 first kept off", err_off, 32'h0010_0000);
        chk("R7 flag sticky", err_flag, 1);
    endtask

    task automatic t_size0_and_clr();
        wr_entry(8'd7, 32'h4000_0000, 32'h0, 1'b0);
        @(negedge clk);
        c_valid = 1; c_plane = 2'd0; c_cfg = 24'd7; c_off = 0; c_we = 1; err_clr = 1;
        @(negedge clk);
        c_valid = 0; err_clr = 0;
        chk("R6 size zero blocked", m_valid, 0);
        chk("R7 clr+new keeps flag", err_flag, 1);
        chk("R7 clr+new captures idx", err_idx, 7);
        chk("R7 clr+new captures off", err_off, 0);
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R7 clear", err_flag, 0);
    endtask

    task automatic t_rewrite();
        wr_entry(8'd10, 32'h0050_0000, 32'h100, 1'b1);
        issue(2'd0, CFG, 32'h8, 1'b1, 64'h0102_0304_0506_0708);
        chk("R2 new base used", m_addr, 32'h0050_0008);
        chk("R2 new flag used", m_wdata, 64'h0807_0605_0403_0201);
        mem_take();
        wr_entry(8'd10, 32'h0001_0000, 32'h0010_0000, 1'b0);
    endtask

    task automatic t_reads();
        issue(2'd1, CFG, 32'h20, 1'b0, 64'h0);
        chk("R4 read m_we", m_we, 0);
        mem_take();
        chk("R10 ready low in read wait", c_ready, 0);
        mem_ret(64'h0102_0304_0506_0708);
        chk("R9 rvalid", c_rvalid, 1);
        chk("R9 big read swap", c_rdata, 64'h0807_0605_0403_0201);
        @(negedge clk);
        chk("R9 rvalid pulse", c_rvalid, 0);
        issue(2'd0, CFG, 32'h20, 1'b0, 64'h0);
        mem_take();
        mem_ret(64'hA1B2_C3D4_E5F6_0718);
        chk("R9 little read", c_rdata, 64'hA1B2_C3D4_E5F6_0718);
    endtask

    task automatic t_stall();
        issue(2'd2, CFG, 32'h4, 1'b1, 64'h55);
        repeat (3) @(negedge clk);
        chk("R10 valid held", m_valid, 1);
        chk("R10 addr held", m_addr, 32'h8000_0004);
        chk("R10 data held", m_wdata, 64'h55);
        chk("R10 client held off", c_ready, 0);
        mem_take();
        chk("R10 released", c_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_little_write();
        t_planes();
        t_bounds();
        t_size0_and_clr();
        t_rewrite();
        t_reads();
        t_stall();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule